// File: doc/BRIEF.md
# Split-Half Pipelined Descending Sorter

This block orders a set of eight unsigned words from largest to smallest in a fully pipelined network. All eight words arrive together on one wide input bus in a single cycle. The ordered set leaves on one wide output bus a fixed number of cycles later. A new set may enter on every cycle, so the sorter sustains one set per clock with no stalls.

Inside, the two halves of the set (lanes 0-3 and lanes 4-7) are first ordered on their own. Each half passes through four alternating bubble tiers of compare-exchange elements. No comparison crosses between the halves until both are fully ordered. Three merge tiers then join the two ordered halves into one ordered set.

Each compare-exchange element uses a single greater-than comparator. Its result steers the larger word toward the lower lane and the smaller word toward the higher lane. A valid flag travels beside the data through a shift register of the same depth, so the flag marks which output sets came from flagged input sets.

Top module: `split_bubble_sorter`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and every lane of data_o is 0, whatever is driven on the inputs.
- R2: On every cycle, lane k of data_o (bits k*DATA_W and up) is greater than or equal to lane k+1, so lane 0 carries the largest word.
- R3: The words on data_o are exactly the words of the input set, including repeated values, reordered and not altered.
- R4: A set sampled at a rising edge appears on data_o after the eighth rising edge that follows from that edge's set (applied in cycle 1, visible in cycle 9), and no earlier result appears after reset.
- R5: valid_o equals the valid_i value sampled with the same set, delayed by the same eight cycles as the data.
- R6: A different set may be applied on every consecutive cycle, and each set comes out sorted in its own cycle without mixing with its neighbours.
- R7: Sets that are all equal, all 0, all the maximum value, already descending, ascending, or built from only a few distinct values are sorted correctly.
- R8: When the same set is held on the inputs for many cycles, data_o holds the same sorted value once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks the input set as meaningful |
| data_i | input | 8*DATA_W | Eight input words, lane k at bits [k*DATA_W +: DATA_W] |
| valid_o | output | 1 | valid_i delayed by the pipeline latency |
| data_o | output | 8*DATA_W | Eight words in descending order, lane 0 largest |

## Verification
The bench builds the sorter with DATA_W at its default of 8. At that width, draws from only four small values produce dense ties across both halves and across the merge boundary. Extremes of 0 and 255 are also reachable. Every set is compared with a reference sort in the cycle its latency dictates. A long stretch of random sets with random valid flags, applied back to back, shows that neighbouring sets stay separate at full rate.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  localparam int LANES     = 8;
  localparam int NUM_TIERS = 7;
  // pipeline depth: input rank plus one rank per tier
  localparam int LAT       = NUM_TIERS + 1;

  // tiers 0-3: alternating bubble tiers inside each half
  // tiers 4-6: merge of the two ordered halves
  // bit i set: lane i paired with lane i+dist, larger word to lane i
  localparam logic [LANES-1:0] TIER_START [NUM_TIERS] =
    '{8'h55, 8'h22, 8'h55, 8'h22, 8'h0F, 8'h0C, 8'h2A};
  localparam int TIER_DIST [NUM_TIERS] = '{1, 1, 1, 1, 4, 2, 1};
endpackage

// File: rtl/cmp_swap.sv
module cmp_swap #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic b_gt_a;

  assign b_gt_a = b_i > a_i;
  assign hi_o   = b_gt_a  ? b_i : a_i;
  assign lo_o   = !b_gt_a ? b_i : a_i;
endmodule

// File: rtl/sort_tier.sv
module sort_tier #(
  parameter int               W     = 8,
  parameter int               L     = 8,
  parameter logic [L-1:0]     START = '0,
  parameter int               DIST  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [L-1:0][W-1:0] d_i,
  output logic [L-1:0][W-1:0] q_o
);
  localparam logic [L-1:0] PARTNER = START << DIST;
  localparam int           SW      = W + $clog2(L);

  logic [L-1:0][W-1:0] nxt;

  for (genvar i = 0; i < L; i++) begin : g_lane
    if (START[i]) begin : g_pair
      cmp_swap #(.W(W)) u_cx (
        .a_i (d_i[i]),
        .b_i (d_i[i+DIST]),
        .hi_o(nxt[i]),
        .lo_o(nxt[i+DIST])
      );

      // R2
      pair_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_o[i] >= q_o[i+DIST]);
    end else if (!PARTNER[i]) begin : g_pass
      assign nxt[i] = d_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end

  function automatic logic [SW-1:0] lane_sum(input logic [L-1:0][W-1:0] v);
    logic [SW-1:0] s;
    s = '0;
    for (int k = 0; k < L; k++) s = s + SW'(v[k]);
    return s;
  endfunction

  // R3
  sum_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> lane_sum(q_o) == $past(lane_sum(d_i)));
endmodule

// File: rtl/split_bubble_sorter.sv
module split_bubble_sorter
  import sorter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [LANES*DATA_W-1:0] data_i,
  output logic                    valid_o,
  output logic [LANES*DATA_W-1:0] data_o
);
  localparam int SW = DATA_W + $clog2(LANES);
  localparam int CW = $clog2(LAT + 1);

  typedef logic [LANES-1:0][DATA_W-1:0] lanes_t;

  lanes_t           stage [NUM_TIERS+1];
  logic [LAT-1:0]   vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage[0] <= '0;
      vld_q    <= '0;
    end else begin
      stage[0] <= lanes_t'(data_i);
      vld_q    <= {vld_q[LAT-2:0], valid_i};
    end
  end

  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
    sort_tier #(
      .W    (DATA_W),
      .L    (LANES),
      .START(TIER_START[t]),
      .DIST (TIER_DIST[t])
    ) u_tier (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (stage[t]),
      .q_o   (stage[t+1])
    );
  end

  assign data_o  = stage[NUM_TIERS];
  assign valid_o = vld_q[LAT-1];

  // checker state: edges seen since reset release, saturating
  logic [CW-1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != LAT) since_rst <= since_rst + 1'b1;
  end

  function automatic logic [SW-1:0] bus_sum(input logic [LANES*DATA_W-1:0] v);
    logic [SW-1:0] s;
    s = '0;
    for (int k = 0; k < LANES; k++) s = s + SW'(v[k*DATA_W +: DATA_W]);
    return s;
  endfunction

  for (genvar k = 0; k < LANES - 1; k++) begin : g_ord
    // R2
    sorted_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_o[k*DATA_W +: DATA_W] >= data_o[(k+1)*DATA_W +: DATA_W]);
  end

  // R4
  latency_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == LAT) |-> bus_sum(data_o) == $past(bus_sum(data_i), LAT));

  // R5
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == LAT) |-> valid_o == $past(valid_i, LAT));
endmodule

// File: tb/sim_split_bubble_sorter.sv
module sim_split_bubble_sorter;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int LN         = 8;
  localparam int LATENCY    = 8;
  localparam int NUM        = 400;
  localparam int VW         = LN * DW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [VW-1:0] data_i = '0;
  logic          valid_o;
  logic [VW-1:0] data_o;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] set_mem [NUM][LN];
  logic          vld_mem [NUM];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  split_bubble_sorter #(.DATA_W(DW)) u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  function automatic logic [VW-1:0] ref_sort(input int idx);
    logic [DW-1:0] v [LN];
    logic [DW-1:0] t;
    logic [VW-1:0] r;
    for (int k = 0; k < LN; k++) v[k] = set_mem[idx][k];
    for (int a = 0; a < LN; a++)
      for (int b = 0; b < LN - 1; b++)
        if (v[b] < v[b+1]) begin
          t = v[b]; v[b] = v[b+1]; v[b+1] = t;
        end
    for (int k = 0; k < LN; k++) r[k*DW +: DW] = v[k];
    return r;
  endfunction

  function automatic logic is_desc(input logic [VW-1:0] v);
    for (int k = 0; k < LN - 1; k++)
      if (v[k*DW +: DW] < v[(k+1)*DW +: DW]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tag_of(input int idx);
    if (idx < 6)   return "R7";
    if (idx < 20)  return "R8";
    if (idx < 220) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] hold [LN];
    void'($urandom(32'd4711));

    // directed sets
    for (int k = 0; k < LN; k++) begin
      set_mem[0][k] = 8'h5A;
      set_mem[1][k] = DW'(k * 3);
      set_mem[2][k] = DW'(200 - k * 7);
      set_mem[3][k] = '0;
      set_mem[4][k] = '1;
      set_mem[5][k] = (k % 2 == 0) ? '1 : '0;
      hold[k]       = DW'($urandom);
    end
    for (int i = 0; i < 6; i++) vld_mem[i] = 1'b1;
    // held set
    for (int i = 6; i < 20; i++) begin
      vld_mem[i] = 1'b1;
      for (int k = 0; k < LN; k++) set_mem[i][k] = hold[k];
    end
    // full-range random, back to back
    for (int i = 20; i < 220; i++) begin
      vld_mem[i] = 1'($urandom);
      for (int k = 0; k < LN; k++) set_mem[i][k] = DW'($urandom);
    end
    // duplicate-heavy random
    for (int i = 220; i < NUM; i++) begin
      vld_mem[i] = 1'($urandom);
      for (int k = 0; k < LN; k++) begin
        case ($urandom % 6)
          0:       set_mem[i][k] = '1;
          1:       set_mem[i][k] = '0;
          default: set_mem[i][k] = DW'($urandom % 4);
        endcase
      end
    end

    // R1: reset holds outputs at zero despite active inputs
    valid_i = 1'b1;
    data_i  = {LN{8'hC3}};
    for (int r = 0; r < 3; r++) begin
      @(negedge clk_i);
      chk("R1 data", data_o, '0);
      chk("R1 valid", VW'(valid_o), '0);
    end

    for (int m = 0; m < NUM + LATENCY; m++) begin
      @(negedge clk_i);
      if (m == 0) rst_ni = 1'b1;
      if (m < LATENCY) begin
        // R4: nothing emerges before the latency has elapsed
        chk("R4 early data", data_o, '0);
        chk("R4 early valid", VW'(valid_o), '0);
      end else begin
        int idx;
        idx = m - LATENCY;
        chk({tag_of(idx), " R3 R4 data"}, data_o, ref_sort(idx));
        chk("R2 order", VW'(is_desc(data_o)), VW'(1'b1));
        chk("R5 valid", VW'(valid_o), VW'(vld_mem[idx]));
      end
      if (m < NUM) begin
        valid_i = vld_mem[m];
        for (int k = 0; k < LN; k++) data_i[k*DW +: DW] = set_mem[m][k];
      end else begin
        valid_i = 1'b0;
        data_i  = '0;
      end
    end

    summary();
    $finish;
  end
endmodule